// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block is the alert-signalling part of an I2C/SMBus target. It pulls a shared, open-drain, active-low alert line whenever its enable bit is set and an interrupt becomes pending. It keeps that line low until a host runs an alert-response read and the block gets its own address through. SCL and SDA are oversampled with the system clock through a synchroniser chain. START and STOP conditions are recovered from the sampled lines, and the block drives SDA only through a pull-low enable.

When the host reads from the alert-response address, a target that held its alert line low at the START acknowledges. It then returns its 7-bit address as one byte, most significant bit first, with a zero in the last bit. Several targets may answer together. Each one checks the wired-AND SDA line while it releases it. A target that sees a 0 where it sent a 1 stops driving for the rest of the byte, so the lowest address comes through intact. The winner releases its alert line at the end of the ninth clock. A loser keeps the alert low so that a later response read can serve it.

Top module: `smbAlertResponder`

## Requirements
- R1: After reset both pull-low outputs are released. With the enable bit set, a high interrupt-pending input drives `alertPullLow` high on the next clock, and it stays high after the input drops.
- R2: Clearing the enable bit releases `alertPullLow` on the next clock. While the enable bit is clear, interrupt-pending has no effect on `alertPullLow`.
- R3: A read from the alert-response address (header byte 0x19, which is address 0001100 followed by R/W = 1) is acknowledged only when `alertPullLow` was already high at the START. Otherwise SDA stays released in the ninth clock.
- R4: Every other header byte is left unacknowledged and leaves the alert state unchanged. This includes 0x18, the same address with R/W = 0.
- R5: After the acknowledge, the block sends the byte {ownAddr, 0} on SDA, most significant bit first, one bit per SCL low phase.
- R6: While it sends that byte, the block samples SDA on each SCL rise. If it sampled 0 while it was releasing SDA for a 1, it drives nothing for the rest of the byte. The bus therefore carries the lowest competing address.
- R7: If the block did not lose arbitration, `alertPullLow` is still high during the high phase of the ninth clock and is released right after that clock's falling edge.
- R8: If the block lost arbitration, `alertPullLow` stays high after the transaction.
- R9: If the host acknowledges a byte it read, the block sends 0xFF bytes until it sees a NACK.
- R10: A START or STOP at any point, including a repeated START in the middle of a header, returns the block to header reception or idle. A following response read then works normally.
- R11: Outside the acknowledge phase and the 0 bits of its reply, the block does not pull SDA low. In particular it leaves SDA released on an idle bus after a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples SCL and SDA |
| rst | input | 1 | Synchronous reset, active high |
| sclIn | input | 1 | Sampled level of the SCL line |
| sdaIn | input | 1 | Sampled level of the SDA line |
| intPending | input | 1 | High while an interrupt waits to be signalled |
| alertEnable | input | 1 | Alert feature enable bit |
| ownAddr | input | 7 | This target's 7-bit bus address |
| sdaPullLow | output | 1 | High to pull SDA low (open-drain enable) |
| alertPullLow | output | 1 | High to pull the shared alert line low |

## Verification
A bad bit counter or transmit register shows up within the first reply byte as a wrong byte on the modelled wired-AND bus. An arbitration flag that sets or clears at the wrong time changes the byte the host reads whenever a competitor has a lower address. A wrong alert latch or release strobe shows within one clock as `alertPullLow` failing to follow the interrupt, or failing to release after the ninth clock. A decoder that accepts the wrong header is caught in that header's ninth clock as an acknowledge where none belongs.

// File: rtl/smbAlertPkg.sv
package smbAlertPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_ACK,
    ST_SEND,
    ST_RACK,
    ST_WAIT
  } stateT;

  // control -> datapath
  typedef struct packed {
    logic clrCnt;
    logic armLatch;
    logic loadAddr;
    logic loadOnes;
    logic ackDrive;
    logic txEnable;
    logic releaseAlert;
  } strobeT;

  // datapath -> control
  typedef struct packed {
    logic startEv;
    logic stopEv;
    logic sclRise;
    logic sclFall;
    logic byteDone;
    logic hdrMatch;
    logic armed;
    logic lost;
    logic lastBit;
  } eventT;

endpackage

// File: rtl/smbAlertDp.sv
module smbAlertDp
  import smbAlertPkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] ARA_ADDR = 7'b0001100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              intPending,
  input  logic              alertEnable,
  input  logic [ADDR_W-1:0] ownAddr,
  input  strobeT            strobe,
  output eventT             events,
  output logic              sdaPullLow,
  output logic              alertPullLow
);

  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [BYTE_W-1:0] HDR_READ = {ARA_ADDR, 1'b1};

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic [CNT_W-1:0] bitCnt;
  logic [BYTE_W-1:0] rxReg, txReg;
  logic lostQ, armedQ, alertQ;

  // synchroniser chain, depth chosen by parameter
  generate
    if (SYNC_STAGES == 1) begin : gSyncSingle
      always_ff @(posedge clk) begin
        if (rst) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= sclIn;
          sdaSync <= sdaIn;
        end
      end
    end else begin : gSyncChain
      always_ff @(posedge clk) begin
        if (rst) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
          sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclS = sclSync[SYNC_STAGES-1];
  assign sdaS = sdaSync[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  // bit counter: counts SCL rises within the current byte
  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt <= '0;
    end else if (strobe.clrCnt) begin
      bitCnt <= '0;
    end else if (events.sclRise && !events.byteDone) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  // receive shift register, sampled on each SCL rise
  always_ff @(posedge clk) begin
    if (rst) begin
      rxReg <= '0;
    end else if (events.sclRise) begin
      rxReg <= {rxReg[BYTE_W-2:0], sdaS};
    end
  end

  // transmit shift register, advanced on SCL fall, refilled with ones
  always_ff @(posedge clk) begin
    if (rst) begin
      txReg <= '1;
    end else if (strobe.loadAddr) begin
      txReg <= {ownAddr, 1'b0};
    end else if (strobe.loadOnes) begin
      txReg <= '1;
    end else if (strobe.txEnable && events.sclFall) begin
      txReg <= {txReg[BYTE_W-2:0], 1'b1};
    end
  end

  // arbitration loss: released for a 1, bus seen low
  always_ff @(posedge clk) begin
    if (rst) begin
      lostQ <= 1'b0;
    end else if (strobe.loadAddr || strobe.loadOnes) begin
      lostQ <= 1'b0;
    end else if (strobe.txEnable && events.sclRise && txReg[BYTE_W-1] && !sdaS) begin
      lostQ <= 1'b1;
    end
  end

  // alert state captured at START
  always_ff @(posedge clk) begin
    if (rst) begin
      armedQ <= 1'b0;
    end else if (strobe.armLatch) begin
      armedQ <= alertQ;
    end
  end

  // alert line: enable gates, pending sets, a won response clears
  always_ff @(posedge clk) begin
    if (rst) begin
      alertQ <= 1'b0;
    end else if (!alertEnable) begin
      alertQ <= 1'b0;
    end else if (intPending) begin
      alertQ <= 1'b1;
    end else if (strobe.releaseAlert) begin
      alertQ <= 1'b0;
    end
  end

  always_comb begin
    events.startEv  = sclS && sclPrev && sdaPrev && !sdaS;
    events.stopEv   = sclS && sclPrev && !sdaPrev && sdaS;
    events.sclRise  = sclS && !sclPrev;
    events.sclFall  = !sclS && sclPrev;
    events.byteDone = (bitCnt == CNT_W'(BYTE_W));
    events.hdrMatch = (rxReg == HDR_READ);
    events.armed    = armedQ;
    events.lost     = lostQ;
    events.lastBit  = rxReg[0];
  end

  assign sdaPullLow   = strobe.ackDrive || (strobe.txEnable && !lostQ && !txReg[BYTE_W-1]);
  assign alertPullLow = alertQ;

endmodule

// File: rtl/smbAlertCtrl.sv
module smbAlertCtrl
  import smbAlertPkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  eventT  events,
  output strobeT strobe
);

  stateT state, stateNext;
  logic firstByte, firstByteNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      firstByte <= 1'b0;
    end else begin
      state     <= stateNext;
      firstByte <= firstByteNext;
    end
  end

  always_comb begin
    stateNext     = state;
    firstByteNext = firstByte;
    strobe        = '0;
    strobe.ackDrive = (state == ST_ACK);
    strobe.txEnable = (state == ST_SEND);

    if (events.startEv) begin
      stateNext       = ST_HDR;
      strobe.clrCnt   = 1'b1;
      strobe.armLatch = 1'b1;
    end else if (events.stopEv) begin
      stateNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: stateNext = ST_IDLE;
        ST_HDR: begin
          if (events.sclFall && events.byteDone) begin
            stateNext = (events.hdrMatch && events.armed) ? ST_ACK : ST_WAIT;
          end
        end
        ST_ACK: begin
          if (events.sclFall) begin
            stateNext       = ST_SEND;
            strobe.loadAddr = 1'b1;
            strobe.clrCnt   = 1'b1;
            firstByteNext   = 1'b1;
          end
        end
        ST_SEND: begin
          if (events.lost) begin
            stateNext = ST_WAIT;
          end else if (events.sclFall && events.byteDone) begin
            stateNext = ST_RACK;
          end
        end
        ST_RACK: begin
          if (events.sclFall) begin
            strobe.releaseAlert = firstByte;
            firstByteNext       = 1'b0;
            if (!events.lastBit) begin
              stateNext       = ST_SEND;
              strobe.loadOnes = 1'b1;
              strobe.clrCnt   = 1'b1;
            end else begin
              stateNext = ST_WAIT;
            end
          end
        end
        ST_WAIT: stateNext = ST_WAIT;
        default: stateNext = ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/smbAlertResponder.sv
module smbAlertResponder
  import smbAlertPkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] ARA_ADDR = 7'b0001100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              intPending,
  input  logic              alertEnable,
  input  logic [ADDR_W-1:0] ownAddr,
  output logic              sdaPullLow,
  output logic              alertPullLow
);

  strobeT strobe;
  eventT  events;
  logic armedFlag, lostFlag, releaseFlag;

  smbAlertCtrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .events (events),
    .strobe (strobe)
  );

  smbAlertDp #(
    .ADDR_W      (ADDR_W),
    .SYNC_STAGES (SYNC_STAGES),
    .ARA_ADDR    (ARA_ADDR)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .sclIn        (sclIn),
    .sdaIn        (sdaIn),
    .intPending   (intPending),
    .alertEnable  (alertEnable),
    .ownAddr      (ownAddr),
    .strobe       (strobe),
    .events       (events),
    .sdaPullLow   (sdaPullLow),
    .alertPullLow (alertPullLow)
  );

  assign armedFlag   = events.armed;
  assign lostFlag    = events.lost;
  assign releaseFlag = strobe.releaseAlert;

endmodule

// File: rtl/smbAlertChecker.sv
module smbAlertChecker (
  input logic clk,
  input logic rst,
  input logic intPending,
  input logic alertEnable,
  input logic alertPullLow,
  input logic sdaPullLow,
  input logic armedFlag,
  input logic lostFlag,
  input logic releaseFlag
);

  // R1: pending with enable asserts the alert on the next clock
  p_alert_set_r1: assert property (@(posedge clk) disable iff (rst)
    (intPending && alertEnable) |=> alertPullLow);

  // R1: the alert rises only because of a pending interrupt
  p_alert_cause_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(alertPullLow) |-> $past(intPending && alertEnable));

  // R2: disabled feature keeps the alert released
  p_enable_off_r2: assert property (@(posedge clk) disable iff (rst)
    !alertEnable |=> !alertPullLow);

  // R3: SDA is only driven after acknowledging while armed
  p_sda_needs_arm_r3: assert property (@(posedge clk) disable iff (rst)
    sdaPullLow |-> armedFlag);

  // R7: the alert falls only on disable, reset or a won response
  p_alert_release_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(alertPullLow) |-> ($past(!alertEnable) || $past(releaseFlag) || $past(rst)));

  // R8: a lost arbitration never releases the alert
  p_release_only_won_r8: assert property (@(posedge clk) disable iff (rst)
    releaseFlag |-> !lostFlag);

endmodule

bind smbAlertResponder smbAlertChecker u_smbAlertChecker (
  .clk          (clk),
  .rst          (rst),
  .intPending   (intPending),
  .alertEnable  (alertEnable),
  .alertPullLow (alertPullLow),
  .sdaPullLow   (sdaPullLow),
  .armedFlag    (armedFlag),
  .lostFlag     (lostFlag),
  .releaseFlag  (releaseFlag)
);

// File: tb/smbAlertResponder_bench.sv
module smbAlertResponder_bench;

  localparam int CLK_PERIOD = 10;
  localparam int QUARTER = 5;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclDrv = 1'b1;
  logic sdaHost = 1'b1;
  logic compPull = 1'b0;
  logic intPending = 1'b0;
  logic alertEnable = 1'b0;
  logic [6:0] ownAddr = 7'h00;
  logic sdaPullLow, alertPullLow;
  logic sdaBus;

  int numChecks = 0;
  int numErrors = 0;

  // competitor model and transaction results
  logic compActive = 1'b0;
  logic compLost = 1'b0;
  logic [6:0] compAddr = 7'h00;
  logic gotAck;
  logic [7:0] rxB [0:2];
  logic alertMid9, alertPost9;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sdaBus = sdaHost & ~sdaPullLow & ~compPull;

  smbAlertResponder u_smbAlertResponder (
    .clk          (clk),
    .rst          (rst),
    .sclIn        (sclDrv),
    .sdaIn        (sdaBus),
    .intPending   (intPending),
    .alertEnable  (alertEnable),
    .ownAddr      (ownAddr),
    .sdaPullLow   (sdaPullLow),
    .alertPullLow (alertPullLow)
  );

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    numChecks++;
    if (act !== exp) begin
      numErrors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic quarter();
    repeat (QUARTER) @(negedge clk);
  endtask

  task automatic clockBit(output logic s);
    quarter();
    sclDrv = 1'b1;
    quarter();
    s = sdaBus;
    quarter();
    sclDrv = 1'b0;
  endtask

  task automatic busStart();
    sdaHost = 1'b1;
    quarter();
    sclDrv = 1'b1;
    quarter();
    sdaHost = 1'b0;
    quarter();
    sclDrv = 1'b0;
  endtask

  task automatic busStop();
    sdaHost = 1'b0;
    quarter();
    sclDrv = 1'b1;
    quarter();
    sdaHost = 1'b1;
    quarter();
    quarter();
  endtask

  task automatic arm();
    intPending = 1'b1;
    @(negedge clk);
    intPending = 1'b0;
    @(negedge clk);
  endtask

  task automatic partialHdr(input logic [7:0] hdr, input int nBits);
    logic s;
    busStart();
    for (int i = 7; i > 7 - nBits; i--) begin
      sdaHost = hdr[i];
      clockBit(s);
    end
  endtask

  task automatic readByte(input bit withComp, output logic [7:0] b);
    logic s;
    logic [7:0] compByte;
    compByte = {compAddr, 1'b0};
    for (int i = 7; i >= 0; i--) begin
      sdaHost = 1'b1;
      compPull = withComp && compActive && !compLost && !compByte[i];
      clockBit(s);
      if (withComp && compActive && !compLost && compByte[i] && !s) compLost = 1'b1;
      b[i] = s;
    end
    compPull = 1'b0;
  endtask

  task automatic araTxn(input logic [7:0] hdr, input int hostAcks);
    logic s;
    compLost = 1'b0;
    rxB[0] = 8'h00; rxB[1] = 8'h00; rxB[2] = 8'h00;
    alertMid9 = 1'bx; alertPost9 = 1'bx;
    busStart();
    for (int i = 7; i >= 0; i--) begin
      sdaHost = hdr[i];
      clockBit(s);
    end
    sdaHost = 1'b1;
    compPull = compActive;
    clockBit(s);
    compPull = 1'b0;
    gotAck = !s;
    if (gotAck) begin
      for (int k = 0; k <= hostAcks; k++) begin
        readByte(k == 0, rxB[k]);
        sdaHost = (k < hostAcks) ? 1'b0 : 1'b1;
        quarter();
        sclDrv = 1'b1;
        quarter();
        if (k == 0) alertMid9 = alertPullLow;
        quarter();
        sclDrv = 1'b0;
        if (k == 0) begin
          repeat (6) @(negedge clk);
          alertPost9 = alertPullLow;
        end
        sdaHost = 1'b1;
      end
    end
    busStop();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    numErrors++;
    numChecks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", numErrors, numChecks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    checkVal("R1 reset alertPullLow", alertPullLow, 1'b0);
    checkVal("R11 reset sdaPullLow", sdaPullLow, 1'b0);

    alertEnable = 1'b1;
    ownAddr = 7'h2B;
    // R3: not armed -> no acknowledge
    araTxn(8'h19, 0);
    checkVal("R3 unarmed ack", gotAck, 1'b0);
    checkVal("R3 unarmed alert", alertPullLow, 1'b0);

    // R1: pending sets alert next clock and it holds
    intPending = 1'b1;
    @(negedge clk);
    checkVal("R1 alert set", alertPullLow, 1'b1);
    intPending = 1'b0;
    repeat (10) @(negedge clk);
    checkVal("R1 alert hold", alertPullLow, 1'b1);

    // R4: every other header is ignored
    for (int h = 0; h < 256; h++) begin
      if (h != 8'h19) begin
        araTxn(8'(h), 0);
        checkVal($sformatf("R4 hdr %0h no ack", h), gotAck, 1'b0);
        checkVal($sformatf("R4 hdr %0h alert kept", h), alertPullLow, 1'b1);
      end
    end

    // R5 / R7: every own address, single responder
    for (int a = 0; a < 128; a++) begin
      ownAddr = 7'(a);
      arm();
      araTxn(8'h19, 0);
      checkVal($sformatf("R3 ack own %0h", a), gotAck, 1'b1);
      checkVal($sformatf("R5 byte own %0h", a), rxB[0], {7'(a), 1'b0});
      checkVal($sformatf("R7 alert in ninth own %0h", a), alertMid9, 1'b1);
      checkVal($sformatf("R7 alert released own %0h", a), alertPost9, 1'b0);
      checkVal($sformatf("R11 idle sda own %0h", a), sdaPullLow, 1'b0);
    end

    // R9: host acknowledges two bytes, then NACK
    ownAddr = 7'h55;
    arm();
    araTxn(8'h19, 2);
    checkVal("R9 first byte", rxB[0], 8'hAA);
    checkVal("R9 fill byte 1", rxB[1], 8'hFF);
    checkVal("R9 fill byte 2", rxB[2], 8'hFF);
    checkVal("R9 alert released", alertPullLow, 1'b0);

    // R6 / R8: arbitration against a competitor
    compActive = 1'b1;
    for (int k = 0; k < 32; k++) begin
      logic [6:0] own, comp, low;
      own = 7'((k * 37 + 5) % 128);
      comp = 7'((k * 53 + 11) % 128);
      if (comp == own) comp = own ^ 7'h01;
      low = (own < comp) ? own : comp;
      ownAddr = own;
      compAddr = comp;
      arm();
      araTxn(8'h19, 0);
      checkVal($sformatf("R6 bus byte own %0h comp %0h", own, comp), rxB[0], {low, 1'b0});
      checkVal($sformatf("R8 alert own %0h comp %0h", own, comp), alertPullLow, (own > comp));
    end
    compActive = 1'b0;

    // R10: STOP in the middle of a header
    ownAddr = 7'h31;
    arm();
    partialHdr(8'h19, 3);
    busStop();
    checkVal("R10 alert after aborted header", alertPullLow, 1'b1);
    araTxn(8'h19, 0);
    checkVal("R10 after stop ack", gotAck, 1'b1);
    checkVal("R10 after stop byte", rxB[0], 8'h62);

    // R10: repeated START in the middle of a header
    ownAddr = 7'h0E;
    arm();
    partialHdr(8'h19, 4);
    araTxn(8'h19, 0);
    checkVal("R10 after restart ack", gotAck, 1'b1);
    checkVal("R10 after restart byte", rxB[0], 8'h1C);

    // R2: disable releases and masks pending
    arm();
    checkVal("R2 armed before disable", alertPullLow, 1'b1);
    alertEnable = 1'b0;
    @(negedge clk);
    checkVal("R2 released on disable", alertPullLow, 1'b0);
    intPending = 1'b1;
    repeat (5) @(negedge clk);
    checkVal("R2 pending masked", alertPullLow, 1'b0);
    intPending = 1'b0;
    araTxn(8'h19, 0);
    checkVal("R2 disabled no ack", gotAck, 1'b0);

    $display("Result: errors=%0d of %0d checks", numErrors, numChecks);
    $finish;
  end

endmodule